// File: doc/BRIEF.md
# Soft-Read Region Composer for Two-Bit Cells

This block turns the comparator outcomes of one two-bit memory cell into soft read data. Each cell is tested against a bank of sensing reference levels. A comparator bit is set when the cell's threshold voltage lies above the corresponding level. The block counts the levels that were passed to get a threshold-region index. From that region it derives hard decisions for both pages stored in the cell, the lower page and the upper page, in a single pass. It then fetches a signed log-likelihood ratio (LLR) for each page from a table that software loads.

A precision select chooses how many reference levels are in use. The four settings correspond to 1.0, 1.4, 1.7 and 2.0 bits per stored bit. Hard-decision reads use only the three symbol boundaries. Each higher setting adds levels inside the overlap around every boundary, which splits that overlap into finer regions. A downstream soft-input decoder consumes the two LLRs. The region index and the error flag are available for monitoring the read channel.

Top module: `mlc_soft_composer`

## Requirements
- R1: The precision select `prec` (0 = 1.0-bit, 1 = 1.4-bit, 2 = 1.7-bit, 3 = 2.0-bit) enables 3, 6, 9 or 15 reference levels. Only the lowest that many bits of `cmp_pass` are used, with bit 0 being the lowest level. Higher bits have no effect on any output.
- R2: `out_region` equals the number of set bits among the enabled comparator bits, giving a range of 0 to the number of enabled levels.
- R3: `out_err` is 1 when the enabled bits are not a thermometer code, that is, when some set bit lies above a clear bit. R2 still applies in that case.
- R4: With k = levels/3 levels per symbol boundary, boundary b (b = 0, 1, 2) is decided by level index b*k + k/2. The cell state is the number of these deciding levels that the region passes (region > b*k + k/2).
- R5: States 0, 1, 2, 3 carry the symbols 11, 01, 00, 10. `out_hard_msb` is the left symbol bit and `out_hard_lsb` is the right symbol bit.
- R6: The table holds 128 signed 6-bit LLRs. The entry at address prec*32 + region*2 + page, written through `lut_we`/`lut_addr`/`lut_wdata`, appears on `out_llr_lsb` (page 0) and on `out_llr_msb` (page 1).
- R7: `out_valid` is `in_valid` delayed by exactly two clock cycles. The other outputs belong to that same request.
- R8: Reset forces `out_valid` to 0 and clears every table entry to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| prec | input | 2 | Precision select |
| cmp_pass | input | 15 | Comparator outcomes, bit 0 is the lowest level |
| lut_we | input | 1 | Table write enable |
| lut_addr | input | 7 | Table write address |
| lut_wdata | input | 6 | Table write data, signed LLR |
| out_valid | output | 1 | Result strobe |
| out_region | output | 4 | Threshold-region index |
| out_hard_lsb | output | 1 | Lower-page hard bit |
| out_hard_msb | output | 1 | Upper-page hard bit |
| out_llr_lsb | output | 6 | Lower-page LLR |
| out_llr_msb | output | 6 | Upper-page LLR |
| out_err | output | 1 | Comparator vector not a thermometer code |

## Verification
The properties treat `prec` and `cmp_pass` as meaningful only in cycles where `in_valid` is high. Their outcomes are defined there for any comparator pattern, so no assumption about monotonic input is needed.

Table writes are assumed not to overlap a request that is still in the pipeline. The stimulus therefore loads every table entry while no request is outstanding, and only then streams requests.

The request stream mixes clean thermometer vectors, vectors with junk above the enabled levels, and fully random vectors. This exercises the error flag and the masking of unused levels in every precision mode.

// File: rtl/msc_pkg.sv
package msc_pkg;
    localparam int MAX_TH = 15;
    localparam int RGN_W  = $clog2(MAX_TH + 1);

    typedef enum logic [1:0] {
        PREC_1P0 = 2'd0,
        PREC_1P4 = 2'd1,
        PREC_1P7 = 2'd2,
        PREC_2P0 = 2'd3
    } prec_e;

    typedef struct packed {
        logic             vld;
        prec_e            prec;
        logic [RGN_W-1:0] rgn;
        logic             lsb;
        logic             msb;
        logic             err;
    } stage_t;

    function automatic int unsigned level_count(prec_e p);
        case (p)
            PREC_1P0: return 3;
            PREC_1P4: return 6;
            PREC_1P7: return 9;
            default:  return 15;
        endcase
    endfunction

    function automatic logic [MAX_TH-1:0] level_mask(prec_e p);
        return {MAX_TH{1'b1}} >> (MAX_TH - level_count(p));
    endfunction
endpackage

// File: rtl/thermo_decode.sv
module thermo_decode import msc_pkg::*; #(
    parameter int NTH = MAX_TH,
    localparam int CW = $clog2(NTH + 1)
) (
    input  logic [NTH-1:0] cmp,
    input  logic [NTH-1:0] mask,
    output logic [CW-1:0]  count,
    output logic           bad
);
    logic [NTH-1:0] act;
    logic [NTH-1:0] ideal;

    always_comb begin
        act   = cmp & mask;
        count = '0;
        for (int i = 0; i < NTH; i++) begin
            count = count + CW'(act[i]);
        end
        ideal = ~({NTH{1'b1}} << count);
        bad   = (act != ideal);
    end
endmodule

// File: rtl/hard_slicer.sv
module hard_slicer import msc_pkg::*; (
    input  prec_e            prec,
    input  logic [RGN_W-1:0] rgn,
    output logic             lsb,
    output logic             msb
);
    int unsigned per_bnd;
    logic [1:0]  state;

    always_comb begin
        per_bnd = level_count(prec) / 3;
        state   = 2'd0;
        for (int unsigned b = 0; b < 3; b++) begin
            if (32'(rgn) > b * per_bnd + per_bnd / 2) begin
                state = state + 2'd1;
            end
        end
        case (state)
            2'd0:    {msb, lsb} = 2'b11;
            2'd1:    {msb, lsb} = 2'b01;
            2'd2:    {msb, lsb} = 2'b00;
            default: {msb, lsb} = 2'b10;
        endcase
    end
endmodule

// File: rtl/llr_table.sv
module llr_table #(
    parameter int LLR_W = 6,
    parameter int AW    = 7,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [LLR_W-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [LLR_W-1:0] rdata_a,
    output logic [LLR_W-1:0] rdata_b
);
    logic [LLR_W-1:0] mem_d [DEPTH];
    logic [LLR_W-1:0] mem_q [DEPTH];
    logic [LLR_W-1:0] rda_d, rdb_d, rda_q, rdb_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
        rda_d = mem_q[raddr_a];
        rdb_d = mem_q[raddr_b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            rda_q <= '0;
            rdb_q <= '0;
        end else begin
            mem_q <= mem_d;
            rda_q <= rda_d;
            rdb_q <= rdb_d;
        end
    end

    assign rdata_a = rda_q;
    assign rdata_b = rdb_q;
endmodule

// File: rtl/mlc_soft_composer.sv
module mlc_soft_composer import msc_pkg::*; #(
    parameter int LLR_W = 6,
    localparam int ADDR_W = 2 + RGN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        prec,
    input  logic [MAX_TH-1:0] cmp_pass,
    input  logic              lut_we,
    input  logic [ADDR_W-1:0] lut_addr,
    input  logic [LLR_W-1:0]  lut_wdata,
    output logic              out_valid,
    output logic [RGN_W-1:0]  out_region,
    output logic              out_hard_lsb,
    output logic              out_hard_msb,
    output logic [LLR_W-1:0]  out_llr_lsb,
    output logic [LLR_W-1:0]  out_llr_msb,
    output logic              out_err
);
    prec_e             prec_in;
    logic [RGN_W-1:0]  rgn_c;
    logic              bad_c, lsb_c, msb_c;
    stage_t            s1_d, s1_q, s2_d, s2_q;
    logic [ADDR_W-1:0] rd_lsb, rd_msb;

    assign prec_in = prec_e'(prec);

    thermo_decode #(.NTH(MAX_TH)) u_thermo (
        .cmp   (cmp_pass),
        .mask  (level_mask(prec_in)),
        .count (rgn_c),
        .bad   (bad_c)
    );

    hard_slicer u_slice (
        .prec (prec_in),
        .rgn  (rgn_c),
        .lsb  (lsb_c),
        .msb  (msb_c)
    );

    always_comb begin
        s1_d.vld  = in_valid;
        s1_d.prec = prec_in;
        s1_d.rgn  = rgn_c;
        s1_d.lsb  = lsb_c;
        s1_d.msb  = msb_c;
        s1_d.err  = bad_c;
        s2_d      = s1_q;
        rd_lsb    = {s1_q.prec, s1_q.rgn, 1'b0};
        rd_msb    = {s1_q.prec, s1_q.rgn, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    llr_table #(.LLR_W(LLR_W), .AW(ADDR_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (lut_we),
        .waddr   (lut_addr),
        .wdata   (lut_wdata),
        .raddr_a (rd_lsb),
        .raddr_b (rd_msb),
        .rdata_a (out_llr_lsb),
        .rdata_b (out_llr_msb)
    );

    assign out_valid    = s2_q.vld;
    assign out_region   = s2_q.rgn;
    assign out_hard_lsb = s2_q.lsb;
    assign out_hard_msb = s2_q.msb;
    assign out_err      = s2_q.err;
endmodule

// File: rtl/msc_checker.sv
module msc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  prec,
    input logic [14:0] cmp_pass,
    input logic        out_valid,
    input logic [3:0]  out_region,
    input logic        out_hard_lsb,
    input logic        out_hard_msb,
    input logic        out_err
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    AST_IDLE_IN_RESET: assert property (@(posedge clk) !rst_n |-> !out_valid); // R8

    AST_TWO_CYCLE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R7

    AST_MONOTONIC_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((cmp_pass & (cmp_pass + 15'd1)) == 15'd0)) |-> ##2 !out_err); // R3

    AST_BOTTOM_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cmp_pass == 15'd0) |-> ##2
        (out_region == 4'd0 && out_hard_lsb && out_hard_msb)); // R5

    AST_TOP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && prec == 2'd3 && cmp_pass == 15'h7FFF) |-> ##2
        (out_region == 4'd15 && !out_hard_lsb && out_hard_msb && !out_err)); // R2
endmodule

bind mlc_soft_composer msc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .prec         (prec),
    .cmp_pass     (cmp_pass),
    .out_valid    (out_valid),
    .out_region   (out_region),
    .out_hard_lsb (out_hard_lsb),
    .out_hard_msb (out_hard_msb),
    .out_err      (out_err)
);

// File: tb/sim_mlc_soft_composer.sv
`timescale 1ns/1ps
module sim_mlc_soft_composer;
    localparam int NT = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  prec = '0;
    logic [14:0] cmp_pass = '0;
    logic        lut_we = 1'b0;
    logic [6:0]  lut_addr = '0;
    logic [5:0]  lut_wdata = '0;
    logic        out_valid, out_hard_lsb, out_hard_msb, out_err;
    logic [3:0]  out_region;
    logic [5:0]  out_llr_lsb, out_llr_msb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [5:0]  lut_model [128];
    logic [1:0]  tv_prec [NT];
    logic [14:0] tv_cmp  [NT];
    logic        tv_vld  [NT];
    int          n_tv = 0;

    always #2.5 clk = ~clk;

    mlc_soft_composer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .prec(prec),
        .cmp_pass(cmp_pass), .lut_we(lut_we), .lut_addr(lut_addr),
        .lut_wdata(lut_wdata), .out_valid(out_valid), .out_region(out_region),
        .out_hard_lsb(out_hard_lsb), .out_hard_msb(out_hard_msb),
        .out_llr_lsb(out_llr_lsb), .out_llr_msb(out_llr_msb), .out_err(out_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nlev(input logic [1:0] p);
        return (p == 2'd0) ? 3 : (p == 2'd1) ? 6 : (p == 2'd2) ? 9 : 15;
    endfunction

    function automatic int exp_region(input logic [1:0] p, input logic [14:0] c);
        int n = 0;
        for (int i = 0; i < nlev(p); i++) if (c[i]) n++;
        return n;
    endfunction

    function automatic bit exp_err(input logic [1:0] p, input logic [14:0] c);
        bit seen_clear = 1'b0;
        for (int i = 0; i < nlev(p); i++) begin
            if (!c[i]) seen_clear = 1'b1;
            else if (seen_clear) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int exp_state(input logic [1:0] p, input int rg);
        int k = nlev(p) / 3;
        int s = 0;
        for (int b = 0; b < 3; b++) if (rg > b * k + k / 2) s++;
        return s;
    endfunction

    task automatic add_tv(input logic [1:0] p, input logic [14:0] c, input logic v);
        tv_prec[n_tv] = p;
        tv_cmp[n_tv]  = c;
        tv_vld[n_tv]  = v;
        n_tv++;
    endtask

    task automatic check_slot(input int j);
        int rg, st;
        logic [1:0] sym;
        chk(out_valid == tv_vld[j], "R7 out_valid", out_valid, tv_vld[j]);
        if (tv_vld[j]) begin
            rg  = exp_region(tv_prec[j], tv_cmp[j]);
            st  = exp_state(tv_prec[j], rg);
            sym = (st == 0) ? 2'b11 : (st == 1) ? 2'b01 : (st == 2) ? 2'b00 : 2'b10;
            chk(int'(out_region) == rg, "R1/R2 region", out_region, rg);
            chk(out_err == exp_err(tv_prec[j], tv_cmp[j]), "R3 err",
                out_err, exp_err(tv_prec[j], tv_cmp[j]));
            chk({out_hard_msb, out_hard_lsb} == sym, "R4/R5 hard symbol",
                {out_hard_msb, out_hard_lsb}, sym);
            chk(out_llr_lsb == lut_model[tv_prec[j] * 32 + rg * 2],
                "R6 llr lsb", out_llr_lsb, lut_model[tv_prec[j] * 32 + rg * 2]);
            chk(out_llr_msb == lut_model[tv_prec[j] * 32 + rg * 2 + 1],
                "R6 llr msb", out_llr_msb, lut_model[tv_prec[j] * 32 + rg * 2 + 1]);
        end
    endtask

    task automatic run_tvs();
        for (int t = 0; t < n_tv + 2; t++) begin
            @(negedge clk);
            if (t >= 2) check_slot(t - 2);
            if (t < n_tv) begin
                in_valid = tv_vld[t];
                prec     = tv_prec[t];
                cmp_pass = tv_cmp[t];
            end else begin
                in_valid = 1'b0;
                cmp_pass = '0;
            end
        end
        n_tv = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int a = 0; a < 128; a++) lut_model[a] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;

        // R8: table cleared by reset, read it before any write
        add_tv(2'd0, 15'h0000, 1'b1);
        add_tv(2'd3, 15'h00FF, 1'b1);
        run_tvs();

        for (int a = 0; a < 128; a++) begin
            @(negedge clk);
            lut_we    = 1'b1;
            lut_addr  = 7'(a);
            lut_wdata = 6'($urandom);
            lut_model[a] = lut_wdata;
        end
        @(negedge clk);
        lut_we = 1'b0;

        // directed corners
        for (int p = 0; p < 4; p++) begin
            add_tv(2'(p), 15'h0000, 1'b1);
            add_tv(2'(p), 15'h7FFF, 1'b1);
            add_tv(2'(p), 15'((1 << nlev(2'(p))) - 1), 1'b1);
            add_tv(2'(p), 15'h0005, 1'b1); // R3 non-monotonic
        end
        add_tv(2'd0, 15'h7FF9, 1'b1); // R1 junk above 3 levels
        add_tv(2'd1, 15'h7FC3, 1'b1); // R1 junk above 6 levels
        add_tv(2'd1, 15'h0002, 1'b1); // R3 lone upper bit
        add_tv(2'd2, 15'h0003, 1'b1); // R4 boundary inside overlap
        add_tv(2'd3, 15'h0007, 1'b1); // R4 exact deciding level
        add_tv(2'd3, 15'h0003, 1'b0); // R7 idle slot
        run_tvs();

        // constrained random
        for (int i = 0; i < 300; i++) begin
            logic [1:0]  p = 2'($urandom);
            int          c = $urandom % (nlev(p) + 1);
            logic [14:0] base = 15'((1 << c) - 1);
            logic [14:0] msk  = 15'((1 << nlev(p)) - 1);
            logic [14:0] v;
            case ($urandom % 4)
                0: v = base;
                1: v = base | (15'($urandom) & ~msk);
                2: v = 15'($urandom);
                default: v = 15'((1 << ($urandom % 16)) - 1);
            endcase
            add_tv(p, v, ($urandom % 5) != 0);
        end
        run_tvs();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule